// File: doc/BRIEF.md
# Link Reservation Monitor for a Shared Memory

This block sits in front of a small word-addressed memory that several requesters share. It supports atomic read-modify-write sequences built from a pair of operations. A linking read returns a word and opens a reservation on that address for the requesting port. A conditional store commits its data only if that reservation is still intact, and it reports the outcome as a one-bit result. Software loops back and retries when that result is zero.

Each port keeps one reservation bit and one reserved address. The bit is dropped when another port's write lands on the reserved word, when the port's context-switch input pulses, or when the port issues a conditional store. Plain reads and writes are also accepted, so the monitor watches every write that reaches the memory. A response for every accepted request appears one cycle later.

Top module: `resv_monitor`

## Requirements
- R1: After reset every response valid is low, every memory word reads zero, and no port holds a reservation, so a conditional store issued straight after reset fails.
- R2: A read or linking read accepted in cycle t raises that port's `rsp_valid` in cycle t+1. `rsp_rdata` carries the word as it stood before any write of cycle t. Op encoding: 0 read, 1 write, 2 linking read, 3 conditional store.
- R3: A linking read followed by a conditional store from the same port to the same address, with no breaking event between them, returns `rsp_sc_ok`=1 and writes the store data.
- R4: A conditional store from a port that holds no reservation returns 0 and leaves memory unchanged.
- R5: A conditional store to an address other than the port's reserved address fails and leaves memory unchanged.
- R6: A write that lands on memory from another port (a plain write or a winning conditional store) drops a reservation on the same address. Writes to other addresses leave it in place, and so do the port's own plain writes.
- R7: `ctx_switch` drops only that port's reservation. A conditional store issued in the same cycle as its port's context switch fails.
- R8: A conditional store drops the issuing port's reservation whatever its outcome, so a second store without a new linking read fails.
- R9: When writes from several ports target one word in the same cycle, the lowest-numbered port wins. Its data is stored, and conditional stores from higher ports fail.
- R10: `rsp_sc_ok` is high only in the response to a conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request strobe per port |
| req_op | input | NPORT x 2 | Operation per port (0 read, 1 write, 2 linking read, 3 conditional store) |
| req_addr | input | NPORT x AW | Word address per port |
| req_wdata | input | NPORT x DW | Store data per port |
| ctx_switch | input | NPORT | Context-switch pulse per port; drops its reservation |
| rsp_valid | output | NPORT | Response strobe, one cycle after the request |
| rsp_rdata | output | NPORT x DW | Word value before the request cycle's writes |
| rsp_sc_ok | output | NPORT | Conditional store succeeded |

## Verification
Directed sequences cover the cases where a buggy monitor would silently break atomicity. A store to a different address that wrongly succeeds would corrupt the word. A foreign write that fails to cancel a reservation would let two conditional stores succeed in turn. A context switch or a second store that fails to drop the bit would let a stale sequence commit. Three ports racing for one word test the priority: a monitor that lets a higher port win, or lets two ports win, stores the wrong data. Random traffic over four hot addresses with occasional context switches is compared each cycle against a reference model of memory and reservations.

// File: rtl/resv_pkg.sv
`timescale 1ns/1ps
package resv_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_LINK  = 2'd2,
      OP_COND  = 2'd3
   } resv_op_e;
endpackage

// File: rtl/resv_arbiter.sv
`timescale 1ns/1ps
// Decides which writes reach memory this cycle and which conditional stores win.
module resv_arbiter
   import resv_pkg::*;
#(
   parameter int NPORT = 3,
   parameter int AW    = 4
) (
   input  logic [NPORT-1:0]          req_valid,
   input  logic [NPORT-1:0][1:0]     req_op,
   input  logic [NPORT-1:0][AW-1:0]  req_addr,
   input  logic [NPORT-1:0]          ctx_switch,
   input  logic [NPORT-1:0]          held,
   input  logic [NPORT-1:0][AW-1:0]  link,
   output logic [NPORT-1:0]          wr_en,
   output logic [NPORT-1:0]          sc_win
);
   logic [NPORT-1:0] lose;

   always_comb begin
      wr_en  = '0;
      sc_win = '0;
      lose   = '0;
      for (int i = 0; i < NPORT; i++) begin
         // a lower port that already writes this word takes priority
         for (int j = 0; j < NPORT; j++) begin
            if (j < i && wr_en[j] && req_addr[j] == req_addr[i]) lose[i] = 1'b1;
         end
         if (req_valid[i]) begin
            if (req_op[i] == OP_WRITE) begin
               wr_en[i] = ~lose[i];
            end else if (req_op[i] == OP_COND) begin
               sc_win[i] = held[i] && (link[i] == req_addr[i]) && !ctx_switch[i] && !lose[i];
               wr_en[i]  = sc_win[i];
            end
         end
      end
   end
endmodule

// File: rtl/resv_slot.sv
`timescale 1ns/1ps
// One port's reservation bit and reserved address, with write snooping.
module resv_slot #(
   parameter int NPORT = 3,
   parameter int AW    = 4,
   parameter int IDX   = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ll_i,
   input  logic                      sc_i,
   input  logic                      ctx_i,
   input  logic [AW-1:0]             addr_i,
   input  logic [NPORT-1:0]          we,
   input  logic [NPORT-1:0][AW-1:0]  waddr,
   output logic                      held_o,
   output logic [AW-1:0]             link_o
);
   logic [AW-1:0] cmp_addr;
   logic          hit;

   assign cmp_addr = ll_i ? addr_i : link_o;

   always_comb begin
      hit = 1'b0;
      for (int j = 0; j < NPORT; j++) begin
         if (j != IDX && we[j] && waddr[j] == cmp_addr) hit = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_o <= 1'b0;
         link_o <= '0;
      end else begin
         if (ll_i) link_o <= addr_i;
         if (ctx_i)      held_o <= 1'b0;
         else if (hit)   held_o <= 1'b0;
         else if (ll_i)  held_o <= 1'b1;
         else if (sc_i)  held_o <= 1'b0;
      end
   end

   assert_ctx_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_i |=> !held_o);
   assert_sc_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sc_i |=> !held_o);
   assert_snoop_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (held_o && !ll_i && we != '0 && (we & ~(NPORT'(1) << IDX)) != '0 &&
       waddr[0] == link_o && we[0] && IDX != 0) |=> !held_o);
endmodule

// File: rtl/resv_store.sv
`timescale 1ns/1ps
// Shared word memory: per-port registered reads, gated writes.
module resv_store #(
   parameter int NPORT = 3,
   parameter int AW    = 4,
   parameter int DW    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NPORT-1:0]          rd_en,
   input  logic [NPORT-1:0]          wr_en,
   input  logic [NPORT-1:0][AW-1:0]  addr,
   input  logic [NPORT-1:0][DW-1:0]  wdata,
   output logic [NPORT-1:0][DW-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
         rdata <= '0;
      end else begin
         for (int i = 0; i < NPORT; i++) begin
            if (rd_en[i]) rdata[i] <= mem[addr[i]];
            if (wr_en[i]) mem[addr[i]] <= wdata[i];
         end
      end
   end

   for (genvar a = 0; a < NPORT; a++) begin : g_wa
      for (genvar b = a + 1; b < NPORT; b++) begin : g_wb
         assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[a] && wr_en[b]) |-> (addr[a] != addr[b]));
      end
   end
endmodule

// File: rtl/resv_monitor.sv
`timescale 1ns/1ps
module resv_monitor
   import resv_pkg::*;
#(
   parameter int NPORT = 3,
   parameter int AW    = 4,
   parameter int DW    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NPORT-1:0]          req_valid,
   input  logic [NPORT-1:0][1:0]     req_op,
   input  logic [NPORT-1:0][AW-1:0]  req_addr,
   input  logic [NPORT-1:0][DW-1:0]  req_wdata,
   input  logic [NPORT-1:0]          ctx_switch,
   output logic [NPORT-1:0]          rsp_valid,
   output logic [NPORT-1:0][DW-1:0]  rsp_rdata,
   output logic [NPORT-1:0]          rsp_sc_ok
);
   if (NPORT < 2 || NPORT > 16) begin : g_bad_nport
      $error("resv_monitor: NPORT must lie in 2..16");
   end
   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("resv_monitor: AW must lie in 1..10");
   end
   if (DW < 1) begin : g_bad_dw
      $error("resv_monitor: DW must be positive");
   end

   logic [NPORT-1:0]         held;
   logic [NPORT-1:0][AW-1:0] link;
   logic [NPORT-1:0]         wr_en;
   logic [NPORT-1:0]         sc_win;
   logic [NPORT-1:0]         is_ll;
   logic [NPORT-1:0]         is_sc;

   for (genvar p = 0; p < NPORT; p++) begin : g_dec
      assign is_ll[p] = req_valid[p] && (req_op[p] == OP_LINK);
      assign is_sc[p] = req_valid[p] && (req_op[p] == OP_COND);
   end

   resv_arbiter #(.NPORT(NPORT), .AW(AW)) u_arb (
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .ctx_switch(ctx_switch),
      .held      (held),
      .link      (link),
      .wr_en     (wr_en),
      .sc_win    (sc_win)
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_slot
      resv_slot #(.NPORT(NPORT), .AW(AW), .IDX(p)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .ll_i  (is_ll[p]),
         .sc_i  (is_sc[p]),
         .ctx_i (ctx_switch[p]),
         .addr_i(req_addr[p]),
         .we    (wr_en),
         .waddr (req_addr),
         .held_o(held[p]),
         .link_o(link[p])
      );
   end

   resv_store #(.NPORT(NPORT), .AW(AW), .DW(DW)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_en(req_valid),
      .wr_en(wr_en),
      .addr (req_addr),
      .wdata(req_wdata),
      .rdata(rsp_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_sc_ok <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_sc_ok <= sc_win;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (held == '0 && rsp_valid == '0));

   for (genvar p = 0; p < NPORT; p++) begin : g_chk
      assert_win_needs_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
         sc_win[p] |-> (held[p] && link[p] == req_addr[p]));
      assert_win_blocks_ctx_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ctx_switch[p] |-> !sc_win[p]);
      assert_ok_only_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_sc_ok[p] |-> (rsp_valid[p] && $past(req_op[p]) == OP_COND));
   end
endmodule

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb;
   localparam int NP = 3;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int DEPTH = 1 << AW;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NP-1:0]          req_valid = '0;
   logic [NP-1:0][1:0]     req_op = '0;
   logic [NP-1:0][AW-1:0]  req_addr = '0;
   logic [NP-1:0][DW-1:0]  req_wdata = '0;
   logic [NP-1:0]          ctx_switch = '0;
   logic [NP-1:0]          rsp_valid;
   logic [NP-1:0][DW-1:0]  rsp_rdata;
   logic [NP-1:0]          rsp_sc_ok;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [DW-1:0] m_mem [DEPTH];
   logic [NP-1:0] m_held;
   logic [AW-1:0] m_link [NP];
   logic [NP-1:0] exp_v;
   logic [NP-1:0] exp_ok;
   logic [DW-1:0] exp_rd [NP];

   always #2.5 clk = ~clk;

   resv_monitor #(.NPORT(NP), .AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .ctx_switch(ctx_switch),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      logic [NP-1:0] we;
      logic lose, hit;
      logic [AW-1:0] tgt;
      we = '0;
      for (int i = 0; i < NP; i++) begin
         exp_v[i]  = req_valid[i];
         exp_rd[i] = m_mem[req_addr[i]];
         exp_ok[i] = 1'b0;
      end
      for (int i = 0; i < NP; i++) begin
         lose = 1'b0;
         for (int j = 0; j < i; j++)
            if (we[j] && req_addr[j] == req_addr[i]) lose = 1'b1;
         if (req_valid[i] && req_op[i] == 2'd1) we[i] = !lose;
         if (req_valid[i] && req_op[i] == 2'd3) begin
            exp_ok[i] = m_held[i] && m_link[i] == req_addr[i] && !ctx_switch[i] && !lose;
            we[i] = exp_ok[i];
         end
      end
      for (int i = 0; i < NP; i++) if (we[i]) m_mem[req_addr[i]] = req_wdata[i];
      for (int i = 0; i < NP; i++) begin
         logic ll, sc;
         ll  = req_valid[i] && req_op[i] == 2'd2;
         sc  = req_valid[i] && req_op[i] == 2'd3;
         tgt = ll ? req_addr[i] : m_link[i];
         hit = 1'b0;
         for (int j = 0; j < NP; j++)
            if (j != i && we[j] && req_addr[j] == tgt) hit = 1'b1;
         if (ll) m_link[i] = req_addr[i];
         if (ctx_switch[i])  m_held[i] = 1'b0;
         else if (hit)       m_held[i] = 1'b0;
         else if (ll)        m_held[i] = 1'b1;
         else if (sc)        m_held[i] = 1'b0;
      end
   endtask

   // one clock: model, edge, compare at the following falling edge
   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
         check("R2 valid", 32'(rsp_valid[i]), 32'(exp_v[i]));
         if (exp_v[i]) check("R2 rdata", 32'(rsp_rdata[i]), 32'(exp_rd[i]));
         check(exp_ok[i] ? "R3 sc_ok" : "R10 sc_ok", 32'(rsp_sc_ok[i]), 32'(exp_ok[i]));
      end
      req_valid  = '0;
      ctx_switch = '0;
   endtask

   task automatic put(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
      req_valid[p] = 1'b1;
      req_op[p]    = op;
      req_addr[p]  = a;
      req_wdata[p] = d;
   endtask

   task automatic read_word(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      put(0, 2'd0, a, '0);
      cyc();
      check(tag, 32'(rsp_rdata[0]), 32'(exp));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd9137));
      for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
      for (int k = 0; k < NP; k++) m_link[k] = '0;
      m_held = '0;
      repeat (3) @(negedge clk);
      check("R1 valid after reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: store straight after reset fails, memory reads zero
      put(1, 2'd3, 4'd5, 16'h0007); cyc();
      check("R1 sc after reset", 32'(rsp_sc_ok[1]), 32'd0);
      read_word(4'd5, 16'h0000, "R4 memory untouched");

      // R3: link then store succeeds
      put(0, 2'd1, 4'd2, 16'h1111); cyc();
      put(0, 2'd2, 4'd2, '0); cyc();
      check("R2 link data", 32'(rsp_rdata[0]), 32'h1111);
      put(0, 2'd3, 4'd2, 16'h2222); cyc();
      check("R3 sc success", 32'(rsp_sc_ok[0]), 32'd1);
      read_word(4'd2, 16'h2222, "R3 stored");

      // R5: store to another address
      put(0, 2'd2, 4'd3, '0); cyc();
      put(0, 2'd3, 4'd4, 16'h0009); cyc();
      check("R5 mismatch fails", 32'(rsp_sc_ok[0]), 32'd0);
      read_word(4'd4, 16'h0000, "R5 memory untouched");

      // R6: unrelated write keeps, foreign winning store breaks
      put(0, 2'd2, 4'd6, '0); put(1, 2'd2, 4'd6, '0); cyc();
      put(2, 2'd1, 4'd7, 16'h0077); cyc();
      put(0, 2'd3, 4'd6, 16'h0066); cyc();
      check("R6 other-address write kept", 32'(rsp_sc_ok[0]), 32'd1);
      put(1, 2'd3, 4'd6, 16'h0166); cyc();
      check("R6 foreign write breaks", 32'(rsp_sc_ok[1]), 32'd0);
      read_word(4'd6, 16'h0066, "R6 loser not stored");
      put(1, 2'd2, 4'd8, '0); cyc();
      put(1, 2'd1, 4'd8, 16'h0808); cyc();
      put(1, 2'd3, 4'd8, 16'h0888); cyc();
      check("R6 own write keeps", 32'(rsp_sc_ok[1]), 32'd1);

      // R7: context switch
      put(2, 2'd2, 4'd9, '0); cyc();
      ctx_switch[2] = 1'b1; cyc();
      put(2, 2'd3, 4'd9, 16'h0999); cyc();
      check("R7 ctx drops", 32'(rsp_sc_ok[2]), 32'd0);
      put(0, 2'd2, 4'd10, '0); put(1, 2'd2, 4'd11, '0); cyc();
      put(0, 2'd3, 4'd10, 16'h0aaa); ctx_switch[1] = 1'b1; cyc();
      check("R7 other port kept", 32'(rsp_sc_ok[0]), 32'd1);
      put(2, 2'd2, 4'd11, '0); cyc();
      put(2, 2'd3, 4'd11, 16'h0bbb); ctx_switch[2] = 1'b1; cyc();
      check("R7 same-cycle ctx fails", 32'(rsp_sc_ok[2]), 32'd0);

      // R8: second store fails
      put(0, 2'd2, 4'd12, '0); cyc();
      put(0, 2'd3, 4'd12, 16'h0c0c); cyc();
      check("R8 first store", 32'(rsp_sc_ok[0]), 32'd1);
      put(0, 2'd3, 4'd12, 16'h0ccc); cyc();
      check("R8 second store fails", 32'(rsp_sc_ok[0]), 32'd0);

      // R9: race for one word
      for (int p = 0; p < NP; p++) put(p, 2'd2, 4'd13, '0);
      cyc();
      for (int p = 0; p < NP; p++) put(p, 2'd3, 4'd13, 16'(16'h00a0 + p));
      cyc();
      check("R9 port0 wins", 32'(rsp_sc_ok), 32'b001);
      read_word(4'd13, 16'h00a0, "R9 winner data");
      for (int p = 0; p < NP; p++) put(p, 2'd1, 4'd14, 16'(p + 1));
      cyc();
      read_word(4'd14, 16'h0001, "R9 plain write priority");

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         for (int p = 0; p < NP; p++) begin
            req_valid[p]  = ($urandom % 4) != 0;
            req_op[p]     = 2'($urandom);
            req_addr[p]   = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 4);
            req_wdata[p]  = DW'($urandom);
            ctx_switch[p] = ($urandom % 16) == 0;
         end
         cyc();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule